// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block is a purely combinational 16-bit arithmetic and logic unit assembled from identical one-bit slices. Each slice holds a full adder and a four-way result selector. A single 3-bit operation code drives every slice. Its upper bit conditionally inverts the B operand and also serves as the carry into the lowest slice. Its lower two bits choose which of four candidate values each slice passes to the result: AND, OR, sum, or a "less" input.

The block offers bitwise AND and OR, addition, subtraction and a signed set-on-less-than. For set-on-less-than, the corrected sign of A minus B is fed back into the less input of slice 0, while every other slice has its less input tied low. Two flags are produced:
- A zero flag, raised when the whole result is zero.
- A signed-overflow flag, which is meaningful only for addition and subtraction.

The carries ripple slice to slice by default. A parameter instead selects a grouped carry-lookahead network that drives the same slices.

Top module: `bitslice_alu`

## Requirements
- R1: Operation code 3'b000 makes the result equal to A AND B.
- R2: Operation code 3'b001 makes the result equal to A OR B.
- R3: Operation code 3'b010 makes the result equal to (A + B) modulo 2^16.
- R4: Operation code 3'b110 makes the result equal to (A - B) modulo 2^16.
- R5: Operation code 3'b111 sets result bit 0 to 1 exactly when A is less than B as two's-complement signed numbers; result bits 15:1 are 0.
- R6: The zero flag is 1 exactly when all 16 result bits are 0.
- R7: For codes 3'b010 and 3'b110, the overflow flag is 1 exactly when the true signed sum or difference lies outside -32768..32767.
- R8: For every code whose bits 1:0 are not 2'b10, the overflow flag is 0.
- R9: Codes 3'b011, 3'b100 and 3'b101 follow the same field decoding. Bit 2 replaces B by NOT B and sets the carry-in to 1. Bits 1:0 select 00 AND, 01 OR, 10 sum, 11 signed-negative indicator of A + B' + bit2 on result bit 0. So 100 gives A AND NOT B, 101 gives A OR NOT B, and 011 sets bit 0 when the true signed A + B is negative.
- R10: With the lookahead carry variant selected, result, zero and overflow are identical to the ripple variant for every operand and code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B |
| op_i | input | 3 | Operation code: bit 2 inverts B and is the carry-in, bits 1:0 pick the slice output |
| result_o | output | 16 | Operation result |
| zero_o | output | 1 | High when the result is all zeros |
| ovf_o | output | 1 | Signed overflow of add or subtract, otherwise low |

## Verification
The hardest case to reach is set-on-less-than when the subtraction itself overflows. Examples are A = 0x8000 with B = 0x0001, and A = 0x7FFF with B = 0xFFFF. In those cases the raw sign bit of the difference gives the wrong answer, and only the overflow correction produces the right one. Uniform random operands rarely land there. The stimulus therefore sweeps every operation code over all pairs of the extreme values 0x0000, 0x0001, 0x7FFF, 0x8000 and 0xFFFF before the random phase. Both carry variants are driven with the same vectors.

// File: rtl/bitslice_alu_pkg.sv
package bitslice_alu_pkg;

   localparam int unsigned OP_W  = 3;
   localparam int unsigned SEL_W = 2;

   typedef enum logic [SEL_W-1:0] {
      SEL_AND  = 2'b00,
      SEL_OR   = 2'b01,
      SEL_SUM  = 2'b10,
      SEL_LESS = 2'b11
   } slice_sel_e;

   typedef enum logic [OP_W-1:0] {
      OP_AND  = 3'b000,
      OP_OR   = 3'b001,
      OP_ADD  = 3'b010,
      OP_SUB  = 3'b110,
      OP_SLT  = 3'b111
   } alu_op_e;

   localparam int unsigned INV_BIT = 2;

endpackage

// File: rtl/bitslice_full_adder.sv
module bitslice_full_adder (
   input  logic x_i,
   input  logic y_i,
   input  logic c_i,
   output logic s_o,
   output logic c_o
);
   logic half_x;

   assign half_x = x_i ^ y_i;
   assign s_o    = half_x ^ c_i;
   assign c_o    = (x_i & y_i) | (half_x & c_i);
endmodule

// File: rtl/bitslice_mux4.sv
module bitslice_mux4 #(
   parameter int unsigned DW = 1
) (
   input  logic [1:0]    sel_i,
   input  logic [DW-1:0] d0_i,
   input  logic [DW-1:0] d1_i,
   input  logic [DW-1:0] d2_i,
   input  logic [DW-1:0] d3_i,
   output logic [DW-1:0] y_o
);
   always_comb begin
      unique case (sel_i)
         2'b00:   y_o = d0_i;
         2'b01:   y_o = d1_i;
         2'b10:   y_o = d2_i;
         default: y_o = d3_i;
      endcase
   end
endmodule

// File: rtl/bitslice_alu_slice.sv
module bitslice_alu_slice
   import bitslice_alu_pkg::*;
(
   input  logic            a_i,
   input  logic            b_i,
   input  logic            cin_i,
   input  logic            less_i,
   input  logic [OP_W-1:0] op_i,
   output logic            res_o,
   output logic            sum_o,
   output logic            cout_o,
   output logic            gen_o,
   output logic            prop_o
);
   logic b_eff;
   logic and_v;
   logic or_v;

   assign b_eff  = b_i ^ op_i[INV_BIT];
   assign and_v  = a_i & b_eff;
   assign or_v   = a_i | b_eff;
   assign gen_o  = and_v;
   assign prop_o = a_i ^ b_eff;

   bitslice_full_adder u_fa (
      .x_i (a_i),
      .y_i (b_eff),
      .c_i (cin_i),
      .s_o (sum_o),
      .c_o (cout_o)
   );

   bitslice_mux4 #(.DW(1)) u_sel (
      .sel_i (op_i[SEL_W-1:0]),
      .d0_i  (and_v),
      .d1_i  (or_v),
      .d2_i  (sum_o),
      .d3_i  (less_i),
      .y_o   (res_o)
   );
endmodule

// File: rtl/bitslice_carry_lookahead.sv
module bitslice_carry_lookahead #(
   parameter int unsigned WIDTH = 16,
   parameter int unsigned GROUP = 4
) (
   input  logic [WIDTH-1:0] gen_i,
   input  logic [WIDTH-1:0] prop_i,
   input  logic             cin_i,
   output logic [WIDTH:0]   carry_o
);
   localparam int unsigned NGRP = WIDTH / GROUP;

   if ((GROUP == 0) || (WIDTH % GROUP != 0)) begin : g_bad_group
      $error("bitslice_carry_lookahead: WIDTH must be a multiple of GROUP");
   end

   always_comb begin
      logic grp_cin;
      logic run_p;
      logic acc_c;
      carry_o    = '0;
      carry_o[0] = cin_i;
      grp_cin    = cin_i;
      for (int grp = 0; grp < NGRP; grp++) begin
         for (int j = 0; j < GROUP; j++) begin
            // two-level sum of products for carry out of bit grp*GROUP+j
            run_p = 1'b1;
            acc_c = 1'b0;
            for (int m = GROUP - 1; m >= 0; m--) begin
               if (m <= j) begin
                  acc_c = acc_c | (gen_i[grp*GROUP+m] & run_p);
                  run_p = run_p & prop_i[grp*GROUP+m];
               end
            end
            carry_o[grp*GROUP+j+1] = acc_c | (run_p & grp_cin);
         end
         grp_cin = carry_o[(grp+1)*GROUP];
      end
   end
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
   import bitslice_alu_pkg::*;
#(
   parameter int unsigned WIDTH         = 16,
   parameter bit          USE_LOOKAHEAD = 1'b0,
   parameter int unsigned LA_GROUP      = 4
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [OP_W-1:0]  op_i,
   output logic [WIDTH-1:0] result_o,
   output logic             zero_o,
   output logic             ovf_o
);
   localparam int unsigned MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("bitslice_alu: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] result_w;
   logic [WIDTH-1:0] gen_w;
   logic [WIDTH-1:0] prop_w;
   logic [WIDTH:0]   la_carry;
   logic             ovf_raw;
   logic             slt_bit;

   for (genvar i = 0; i < WIDTH; i++) begin : g_slice
      logic cin_l;
      logic cout_l;
      logic cout_eff;
      logic sum_l;
      logic res_l;

      if (USE_LOOKAHEAD) begin : g_la_cin
         logic unused_fa_cout;
         assign cin_l          = la_carry[i];
         assign cout_eff       = la_carry[i+1];
         assign unused_fa_cout = cout_l;
      end else if (i == 0) begin : g_first_cin
         assign cin_l    = op_i[INV_BIT];
         assign cout_eff = cout_l;
      end else begin : g_ripple_cin
         assign cin_l    = g_slice[i-1].cout_l;
         assign cout_eff = cout_l;
      end

      bitslice_alu_slice u_bit (
         .a_i    (a_i[i]),
         .b_i    (b_i[i]),
         .cin_i  (cin_l),
         .less_i ((i == 0) ? slt_bit : 1'b0),
         .op_i   (op_i),
         .res_o  (res_l),
         .sum_o  (sum_l),
         .cout_o (cout_l),
         .gen_o  (gen_w[i]),
         .prop_o (prop_w[i])
      );

      assign result_w[i] = res_l;
   end

   if (USE_LOOKAHEAD) begin : g_lookahead
      bitslice_carry_lookahead #(
         .WIDTH (WIDTH),
         .GROUP (LA_GROUP)
      ) u_cla (
         .gen_i   (gen_w),
         .prop_i  (prop_w),
         .cin_i   (op_i[INV_BIT]),
         .carry_o (la_carry)
      );
   end else begin : g_ripple
      logic unused_ripple;
      assign la_carry      = '0;
      assign unused_ripple = ^{la_carry, gen_w, prop_w};
   end

   // signed overflow: carry into the top slice differs from carry out of it
   assign ovf_raw  = g_slice[MSB].cin_l ^ g_slice[MSB].cout_eff;
   assign slt_bit  = g_slice[MSB].sum_l ^ ovf_raw;

   assign result_o = result_w;
   assign zero_o   = ~|result_w;
   assign ovf_o    = ovf_raw & (op_i[SEL_W-1:0] == SEL_SUM);
endmodule

// File: rtl/bitslice_alu_checker.sv
module bitslice_alu_checker
   import bitslice_alu_pkg::*;
#(
   parameter int unsigned WIDTH = 16
) (
   input logic [WIDTH-1:0] a_i,
   input logic [WIDTH-1:0] b_i,
   input logic [OP_W-1:0]  op_i,
   input logic [WIDTH-1:0] result_o,
   input logic             zero_o,
   input logic             ovf_o
);
   logic [WIDTH-1:0] sum_ref;
   logic [WIDTH-1:0] diff_ref;

   assign sum_ref  = a_i + b_i;
   assign diff_ref = a_i - b_i;

   always_comb begin
      if (!$isunknown({a_i, b_i, op_i, result_o, zero_o, ovf_o})) begin
         if (op_i == 3'b000) begin
            assert_and_R1: assert (result_o == (a_i & b_i))
               else $error("AND result wrong");
         end
         if (op_i == 3'b001) begin
            assert_or_R2: assert (result_o == (a_i | b_i))
               else $error("OR result wrong");
         end
         if (op_i == 3'b010) begin
            assert_add_R3: assert (result_o == sum_ref)
               else $error("add result wrong");
         end
         if (op_i == 3'b110) begin
            assert_sub_R4: assert (result_o == diff_ref)
               else $error("subtract result wrong");
         end
         if (op_i == 3'b111) begin
            assert_slt_upper_R5: assert (result_o[WIDTH-1:1] == '0)
               else $error("set-less-than upper bits not clear");
         end
         if (op_i[1:0] != 2'b10) begin
            assert_no_overflow_R8: assert (!ovf_o)
               else $error("overflow raised outside add/subtract");
         end
         if (zero_o) begin
            assert_zero_R6: assert (result_o == '0)
               else $error("zero flag with nonzero result");
         end
      end
   end
endmodule

bind bitslice_alu bitslice_alu_checker #(.WIDTH(WIDTH)) u_checker (
   .a_i      (a_i),
   .b_i      (b_i),
   .op_i     (op_i),
   .result_o (result_o),
   .zero_o   (zero_o),
   .ovf_o    (ovf_o)
);

// File: tb/bitslice_alu_bench.sv
module bitslice_alu_bench;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] a = '0;
   logic [W-1:0] b = '0;
   logic [2:0]   op = '0;
   logic [W-1:0] res_r, res_c;
   logic         z_r, z_c, v_r, v_c;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   bitslice_alu #(.WIDTH(W), .USE_LOOKAHEAD(1'b0)) u_bitslice_alu (
      .a_i(a), .b_i(b), .op_i(op), .result_o(res_r), .zero_o(z_r), .ovf_o(v_r)
   );

   bitslice_alu #(.WIDTH(W), .USE_LOOKAHEAD(1'b1), .LA_GROUP(4)) u_bitslice_alu_cla (
      .a_i(a), .b_i(b), .op_i(op), .result_o(res_c), .zero_o(z_c), .ovf_o(v_c)
   );

   function automatic void model(input logic [W-1:0] x, input logic [W-1:0] y,
                                 input logic [2:0] code, output logic [W-1:0] r,
                                 output logic z, output logic v);
      logic [W-1:0] yb;
      int sx, sy, s;
      logic ov, lt;
      yb = code[2] ? ~y : y;
      sx = int'($signed(x));
      sy = int'($signed(yb));
      s  = sx + sy + (code[2] ? 1 : 0);
      ov = (s > 32767) || (s < -32768);
      lt = (s < 0);
      case (code[1:0])
         2'b00:   r = x & yb;
         2'b01:   r = x | yb;
         2'b10:   r = s[W-1:0];
         default: r = {{(W-1){1'b0}}, lt};
      endcase
      z = (r == '0);
      v = ov && (code[1:0] == 2'b10);
   endfunction

   function automatic string res_tag(input logic [2:0] code);
      case (code)
         3'b000:  return "R1";
         3'b001:  return "R2";
         3'b010:  return "R3";
         3'b110:  return "R4";
         3'b111:  return "R5";
         default: return "R9";
      endcase
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [W-1:0] got, input logic [W-1:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s a=%h b=%h op=%b actual=%h expected=%h",
                  tag, what, a, b, op, got, exp);
      end
   endtask

   task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic [2:0] code);
      logic [W-1:0] er;
      logic ez, ev;
      @(posedge clk);
      #2;
      a = x; b = y; op = code;
      #3;
      model(x, y, code, er, ez, ev);
      chk(res_tag(code), "result", res_r, er);
      chk("R6", "zero", {{(W-1){1'b0}}, z_r}, {{(W-1){1'b0}}, ez});
      chk((code[1:0] == 2'b10) ? "R7" : "R8", "overflow",
          {{(W-1){1'b0}}, v_r}, {{(W-1){1'b0}}, ev});
      chk("R10", "lookahead result", res_c, er);
      chk("R10", "lookahead zero", {{(W-1){1'b0}}, z_c}, {{(W-1){1'b0}}, ez});
      chk("R10", "lookahead overflow", {{(W-1){1'b0}}, v_c}, {{(W-1){1'b0}}, ev});
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      logic [W-1:0] corner [5];
      corner[0] = 16'h0000; corner[1] = 16'h0001; corner[2] = 16'h7FFF;
      corner[3] = 16'h8000; corner[4] = 16'hFFFF;
      void'($urandom(32'd20240611));

      repeat (3) @(posedge clk);
      #5;
      // idle state with all-zero inputs: result 0, zero set, no overflow (R6)
      chk("R6", "idle result", res_r, '0);
      chk("R6", "idle zero", {{(W-1){1'b0}}, z_r}, {{(W-1){1'b0}}, 1'b1});
      chk("R8", "idle overflow", {{(W-1){1'b0}}, v_r}, '0);
      rst_n = 1'b1;

      // directed: every code over all extreme operand pairs (R5 overflow-corrected SLT, R7)
      for (int c = 0; c < 8; c++)
         for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
               apply(corner[i], corner[j], 3'(c));

      apply(16'h8000, 16'h0001, 3'b111);   // R5: -32768 < 1 despite overflow
      apply(16'h7FFF, 16'hFFFF, 3'b111);   // R5: 32767 > -1 despite overflow
      apply(16'h1234, 16'h1234, 3'b110);   // R4/R6: equal operands give zero
      apply(16'h4000, 16'h4000, 3'b010);   // R7: positive overflow on add

      // random phase, with equal-operand and sign-boundary bias
      for (int n = 0; n < 3000; n++) begin
         logic [W-1:0] x, y;
         logic [2:0] c;
         x = W'($urandom);
         y = W'($urandom);
         c = 3'($urandom);
         if (($urandom % 8) == 0) y = x;
         if (($urandom % 8) == 0) x[W-1] = ~x[W-1];
         apply(x, y, c);
      end
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end
endmodule